// File: doc/BRIEF.md
# SDRAM Access Command Sequencer

This block turns one host burst request at a time into the command stream for a four-bank, 32-bit synchronous DRAM. The host gives a flat word address, a direction and, for writes, a stream of data words. The sequencer splits the address into bank, row and column fields. It opens the row, waits out the row-to-column delay and issues the column command. It moves the burst, closes the row and then pulses `host_ack`.

After every reset the block first programs the DRAM mode register from `cfg_burst` and `cfg_cas`. It accepts no host request until that load has finished. Fixed bursts of 1, 2, 4 or 8 close the row through the auto-precharge flag on the column command. A full-page burst is stopped with a burst-terminate command and closed with an explicit single-bank precharge.

Read beats come back on `host_rd_valid`/`host_rdata`. Write beats are taken from `host_wdata`, and `host_wr_next` pulses once for each word consumed.

Top module: `sdram_seq_top`

## Requirements
- R1: While reset is high and just after it, the pins carry NOP ({cs_n,ras_n,cas_n,we_n}=0111) with the data bus undriven and `host_ack`/`host_rd_valid` low. The first command after reset is LOAD MODE (0000), and no ACTIVE (0011) comes before it even if a request is pending.
- R2: The LOAD MODE address holds the burst code on bits [2:0] and {0,CAS latency} on bits [6:4]; all other bits are zero. Burst codes are 000=1, 001=2, 010=4, 011=8 and 111=full page (2^COL_W words).
- R3: The host address is split as {bank, row, column}, with the column in the low COL_W bits. ACTIVE carries the bank on `sd_ba` and the row on `sd_a`.
- R4: READ (0101) or WRITE (0100) appears exactly T_RCD cycles after ACTIVE. It carries the same bank and has the start column on `sd_a[COL_W-1:0]`.
- R5: For bursts of 1, 2, 4 or 8, `sd_a[10]` is high on the column command, and no PRECHARGE or burst-terminate is issued for that access.
- R6: For a full-page burst, `sd_a[10]` is low on the column command. Burst-terminate (0110) follows exactly 2^COL_W cycles after it. A PRECHARGE (0010) with `sd_a[10]` low to the same bank then closes the row.
- R7: For a write, beat k is driven on `sd_dq_out` with `sd_dq_oe` high in the k-th cycle after the WRITE cycle (k=0 is the WRITE cycle itself). `host_wr_next` pulses once per beat, exactly burst-length times in all.
- R8: For a read, the word sampled CL+k rising edges after the edge that samples READ is returned as beat k. There are exactly burst-length `host_rd_valid` pulses before `host_ack`, in the DRAM's sequential wrapped column order.
- R9: `host_ack` is a one-cycle pulse per request. It comes after the last data beat of that request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cfg_burst | input | 3 | Burst code loaded after reset |
| cfg_cas | input | 2 | CAS latency (1 to 3) loaded after reset |
| host_req | input | 1 | Request, held until ack |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | HADDR_W | Flat word address {bank,row,column} |
| host_wdata | input | DATA_W | Current write word |
| host_ack | output | 1 | Request complete pulse |
| host_wr_next | output | 1 | Write word taken, present the next one |
| host_rd_valid | output | 1 | Read beat valid |
| host_rdata | output | DATA_W | Read beat data |
| sd_cs_n | output | 1 | Chip select, low active |
| sd_ras_n | output | 1 | Row strobe, low active |
| sd_cas_n | output | 1 | Column strobe, low active |
| sd_we_n | output | 1 | Write enable, low active |
| sd_ba | output | BANK_W | Bank address |
| sd_a | output | ROW_W | Row / column / mode address |
| sd_dq_out | output | DATA_W | Write data to the DRAM |
| sd_dq_oe | output | 1 | Drive enable for sd_dq_out |
| sd_dq_in | input | DATA_W | Read data from the DRAM |

## Verification
The bench builds the block with COL_W=4, so a full-page burst is 16 beats. That lets the burst-terminate placement and the explicit precharge be seen in a short run. T_RCD is set to 3 so that an off-by-one in the activate-to-column gap is visible; the other delays stay at 2. Every burst code and all three CAS latencies are reached by resetting and reloading between phases. Start columns are chosen so that bursts wrap within their aligned block.

// File: rtl/sdseq_pkg.sv
package sdseq_pkg;
  // {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_LMR = 4'b0000,
    CMD_PRE = 4'b0010,
    CMD_ACT = 4'b0011,
    CMD_WR  = 4'b0100,
    CMD_RD  = 4'b0101,
    CMD_BT  = 4'b0110,
    CMD_NOP = 4'b0111
  } sd_cmd_e;

  typedef enum logic [3:0] {
    ST_LMR, ST_LMR_WAIT, ST_IDLE, ST_RCD, ST_BURST,
    ST_TERM, ST_PRE_GAP, ST_TAIL, ST_ACK
  } seq_state_e;

  localparam logic [2:0] BLC_FULL = 3'b111;
endpackage

// File: rtl/sdseq_addr_split.sv
module sdseq_addr_split #(
  parameter int BANK_W = 2,
  parameter int ROW_W  = 13,
  parameter int COL_W  = 9,
  parameter int HADDR_W = BANK_W + ROW_W + COL_W
) (
  input  logic [HADDR_W-1:0] flat,
  output logic [BANK_W-1:0]  bank,
  output logic [ROW_W-1:0]   row,
  output logic [COL_W-1:0]   col
);
  assign bank = flat[HADDR_W-1 -: BANK_W];
  assign row  = flat[COL_W +: ROW_W];
  assign col  = flat[COL_W-1:0];
endmodule

// File: rtl/sdseq_timer.sv
module sdseq_timer #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] val,
  output logic         zero
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)             cnt <= '0;
    else if (load)       cnt <= val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/sdseq_rd_return.sv
module sdseq_rd_return #(
  parameter int DATA_W = 32,
  parameter int MAX_CL = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              slot,
  input  logic [1:0]        cl,
  input  logic [DATA_W-1:0] dq_in,
  output logic [DATA_W-1:0] rdata,
  output logic              rd_valid
);
  logic [MAX_CL-1:0] dly;
  logic [1:0]        pick;
  logic              capture;

  assign pick    = (cl == 2'd0) ? 2'd0 : cl - 2'd1;
  assign capture = dly[pick];

  always_ff @(posedge clk) begin
    if (rst) begin
      dly      <= '0;
      rd_valid <= 1'b0;
    end else begin
      dly      <= {dly[MAX_CL-2:0], slot};
      rd_valid <= capture;
    end
  end

  always_ff @(posedge clk) begin
    if (capture) rdata <= dq_in;
  end
endmodule

// File: rtl/sdram_seq_top.sv
module sdram_seq_top
  import sdseq_pkg::*;
#(
  parameter int BANK_W  = 2,
  parameter int ROW_W   = 13,
  parameter int COL_W   = 9,
  parameter int DATA_W  = 32,
  parameter int T_RCD   = 2,
  parameter int T_RP    = 2,
  parameter int T_WR    = 2,
  parameter int T_MRD   = 2,
  parameter int HADDR_W = BANK_W + ROW_W + COL_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [2:0]         cfg_burst,
  input  logic [1:0]         cfg_cas,
  input  logic               host_req,
  input  logic               host_we,
  input  logic [HADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0]  host_wdata,
  output logic               host_ack,
  output logic               host_wr_next,
  output logic               host_rd_valid,
  output logic [DATA_W-1:0]  host_rdata,
  output logic               sd_cs_n,
  output logic               sd_ras_n,
  output logic               sd_cas_n,
  output logic               sd_we_n,
  output logic [BANK_W-1:0]  sd_ba,
  output logic [ROW_W-1:0]   sd_a,
  output logic [DATA_W-1:0]  sd_dq_out,
  output logic               sd_dq_oe,
  input  logic [DATA_W-1:0]  sd_dq_in
);
  localparam int BEAT_W = COL_W + 1;
  localparam int TMR_W  = $clog2(T_RCD + T_WR + T_RP + T_MRD + 8);

  seq_state_e        state;
  sd_cmd_e           cmd_q;
  logic [BANK_W-1:0] ba_q, bank_r, sp_bank;
  logic [ROW_W-1:0]  a_q, row_r, sp_row, mode_word, col_word;
  logic [COL_W-1:0]  col_r, sp_col;
  logic [DATA_W-1:0] dq_q;
  logic              oe_q, wr_next_q, slot_q, ack_q, we_r, full_r;
  logic [1:0]        cl_r;
  logic [BEAT_W-1:0] beat_q, len_r;
  logic              tmr_load, tmr_zero, burst_last;
  logic [TMR_W-1:0]  tmr_val;

  function automatic logic [BEAT_W-1:0] burst_len(input logic [2:0] code);
    case (code)
      3'd0, 3'd1, 3'd2, 3'd3: burst_len = BEAT_W'(1) << code[1:0];
      BLC_FULL:               burst_len = BEAT_W'(1) << COL_W;
      default:                burst_len = BEAT_W'(1);
    endcase
  endfunction

  sdseq_addr_split #(.BANK_W(BANK_W), .ROW_W(ROW_W), .COL_W(COL_W), .HADDR_W(HADDR_W))
    u_split (.flat(host_addr), .bank(sp_bank), .row(sp_row), .col(sp_col));

  sdseq_timer #(.W(TMR_W))
    u_timer (.clk(clk), .rst(rst), .load(tmr_load), .val(tmr_val), .zero(tmr_zero));

  sdseq_rd_return #(.DATA_W(DATA_W), .MAX_CL(3))
    u_rret (.clk(clk), .rst(rst), .slot(slot_q), .cl(cl_r), .dq_in(sd_dq_in),
            .rdata(host_rdata), .rd_valid(host_rd_valid));

  always_comb begin
    mode_word      = '0;
    mode_word[2:0] = cfg_burst;
    mode_word[6:4] = {1'b0, cfg_cas};
    col_word              = '0;
    col_word[COL_W-1:0]   = col_r;
    col_word[10]          = ~full_r;
  end

  assign burst_last = (state == ST_RCD) ? (len_r == BEAT_W'(1))
                                        : ((beat_q + 1'b1) == len_r);

  // Timer reload points
  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = '0;
    case (state)
      ST_LMR: begin
        tmr_load = 1'b1;
        tmr_val  = TMR_W'(T_MRD - 1);
      end
      ST_IDLE: if (host_req) begin
        tmr_load = 1'b1;
        tmr_val  = TMR_W'(T_RCD - 1);
      end
      ST_RCD, ST_BURST: if ((state == ST_BURST || tmr_zero) && burst_last && !full_r) begin
        tmr_load = 1'b1;
        tmr_val  = we_r ? TMR_W'(T_WR + T_RP - 1) : TMR_W'(int'(cl_r) + T_RP - 1);
      end
      ST_TERM: begin
        tmr_load = 1'b1;
        tmr_val  = we_r ? TMR_W'(T_WR - 1) : '0;
      end
      ST_PRE_GAP: if (tmr_zero) begin
        tmr_load = 1'b1;
        tmr_val  = TMR_W'(int'(cl_r) + T_RP - 1);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_LMR;
      cmd_q     <= CMD_NOP;
      ba_q      <= '0;
      a_q       <= '0;
      dq_q      <= '0;
      oe_q      <= 1'b0;
      wr_next_q <= 1'b0;
      slot_q    <= 1'b0;
      ack_q     <= 1'b0;
      beat_q    <= '0;
      len_r     <= BEAT_W'(1);
      bank_r    <= '0;
      row_r     <= '0;
      col_r     <= '0;
      we_r      <= 1'b0;
      full_r    <= 1'b0;
      cl_r      <= 2'd1;
    end else begin
      cmd_q     <= CMD_NOP;
      oe_q      <= 1'b0;
      wr_next_q <= 1'b0;
      slot_q    <= 1'b0;
      ack_q     <= 1'b0;
      case (state)
        ST_LMR: begin
          cmd_q  <= CMD_LMR;
          ba_q   <= '0;
          a_q    <= mode_word;
          cl_r   <= cfg_cas;
          full_r <= (cfg_burst == BLC_FULL);
          len_r  <= burst_len(cfg_burst);
          state  <= ST_LMR_WAIT;
        end
        ST_LMR_WAIT: if (tmr_zero) state <= ST_IDLE;
        ST_IDLE: if (host_req) begin
          cmd_q  <= CMD_ACT;
          ba_q   <= sp_bank;
          a_q    <= sp_row;
          bank_r <= sp_bank;
          row_r  <= sp_row;
          col_r  <= sp_col;
          we_r   <= host_we;
          state  <= ST_RCD;
        end
        ST_RCD, ST_BURST: if (state == ST_BURST || tmr_zero) begin
          if (state == ST_RCD) begin
            cmd_q  <= we_r ? CMD_WR : CMD_RD;
            ba_q   <= bank_r;
            a_q    <= col_word;
            beat_q <= BEAT_W'(1);
          end else begin
            beat_q <= beat_q + 1'b1;
          end
          if (we_r) begin
            dq_q      <= host_wdata;
            oe_q      <= 1'b1;
            wr_next_q <= 1'b1;
          end else begin
            slot_q    <= 1'b1;
          end
          if (burst_last) state <= full_r ? ST_TERM : ST_TAIL;
          else            state <= ST_BURST;
        end
        ST_TERM: begin
          cmd_q <= CMD_BT;
          state <= ST_PRE_GAP;
        end
        ST_PRE_GAP: if (tmr_zero) begin
          cmd_q <= CMD_PRE;
          ba_q  <= bank_r;
          a_q   <= '0;
          state <= ST_TAIL;
        end
        ST_TAIL: if (tmr_zero) begin
          ack_q <= 1'b1;
          state <= ST_ACK;
        end
        ST_ACK:  state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd_q;
  assign sd_ba        = ba_q;
  assign sd_a         = a_q;
  assign sd_dq_out    = dq_q;
  assign sd_dq_oe     = oe_q;
  assign host_ack     = ack_q;
  assign host_wr_next = wr_next_q;
endmodule

// File: rtl/sdseq_chk.sv
module sdseq_chk #(
  parameter int ROW_W = 13
) (
  input logic             clk,
  input logic             rst,
  input logic             host_ack,
  input logic             host_rd_valid,
  input logic             host_wr_next,
  input logic             sd_dq_oe,
  input logic             sd_cs_n,
  input logic             sd_ras_n,
  input logic             sd_cas_n,
  input logic             sd_we_n,
  input logic [ROW_W-1:0] sd_a
);
  logic [3:0] cmd;
  logic       seen_mode;

  assign cmd = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};

  always_ff @(posedge clk) begin
    if (rst)                  seen_mode <= 1'b0;
    else if (cmd == 4'b0000)  seen_mode <= 1'b1;
  end

  // R1
  act_after_mode_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd == 4'b0011) |-> seen_mode);

  // R9
  ack_single_chk: assert property (@(posedge clk) disable iff (rst)
    host_ack |=> !host_ack);

  // R7
  wr_beat_driven_chk: assert property (@(posedge clk) disable iff (rst)
    host_wr_next |-> sd_dq_oe);

  // R8
  rd_beat_quiet_bus_chk: assert property (@(posedge clk) disable iff (rst)
    host_rd_valid |-> !sd_dq_oe);

  // R6
  pre_one_bank_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd == 4'b0010) |-> !sd_a[10]);

  // R5
  autopre_no_follow_chk: assert property (@(posedge clk) disable iff (rst)
    ((cmd == 4'b0101 || cmd == 4'b0100) && sd_a[10]) |=> (cmd == 4'b0111));
endmodule

bind sdram_seq_top sdseq_chk #(.ROW_W(ROW_W)) u_chk (
  .clk(clk), .rst(rst), .host_ack(host_ack), .host_rd_valid(host_rd_valid),
  .host_wr_next(host_wr_next), .sd_dq_oe(sd_dq_oe), .sd_cs_n(sd_cs_n),
  .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n), .sd_a(sd_a)
);

// File: tb/sdram_seq_top_test.sv
module sdram_seq_top_test;
  localparam int BW = 2, RW = 13, CW = 4, DW = 32;
  localparam int TRCD = 3, TRP = 2, TWR = 2, TMRD = 2;
  localparam int HW = BW + RW + CW;
  localparam int PAGE = 1 << CW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [2:0] cfg_burst = 3'd0;
  logic [1:0] cfg_cas = 2'd1;
  logic req = 1'b0, we = 1'b0;
  logic [HW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic ack, wr_next, rd_valid;
  logic [DW-1:0] rdata;
  logic cs_n, ras_n, cas_n, we_n;
  logic [BW-1:0] ba;
  logic [RW-1:0] a;
  logic [DW-1:0] dq_out;
  logic dq_oe;
  logic [DW-1:0] dq_in = '0;

  always #5 clk = ~clk;

  sdram_seq_top #(.BANK_W(BW), .ROW_W(RW), .COL_W(CW), .DATA_W(DW),
                  .T_RCD(TRCD), .T_RP(TRP), .T_WR(TWR), .T_MRD(TMRD)) uut (
    .clk(clk), .rst(rst), .cfg_burst(cfg_burst), .cfg_cas(cfg_cas),
    .host_req(req), .host_we(we), .host_addr(addr), .host_wdata(wdata),
    .host_ack(ack), .host_wr_next(wr_next), .host_rd_valid(rd_valid), .host_rdata(rdata),
    .sd_cs_n(cs_n), .sd_ras_n(ras_n), .sd_cas_n(cas_n), .sd_we_n(we_n),
    .sd_ba(ba), .sd_a(a), .sd_dq_out(dq_out), .sd_dq_oe(dq_oe), .sd_dq_in(dq_in));

  int checks = 0, errors = 0;
  int cyc = 0;
  int cur_bl = 1, cur_cl = 1;
  logic [2:0] cur_code = 3'd0;
  int exp_bank, exp_row, exp_col;
  bit exp_full;
  logic [DW-1:0] ref_mem[int];
  logic [DW-1:0] dram_mem[int];
  logic [DW-1:0] sched[int];
  logic [DW-1:0] exp_q[$];
  int rd_seen = 0;

  // model state
  bit mdl_loaded = 0;
  int act_cyc = 0, rw_cyc = 0, rw_bank = 0, rw_row = 0, rw_col = 0, wr_k = 0;
  bit wr_active = 0;

  task automatic check(input bit ok, input string tag, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h (cycle %0d)", tag, act, expv, cyc);
    end
  endtask

  function automatic int key(input int b, input int r, input int c);
    return (b << 17) | (r << 4) | c;
  endfunction

  function automatic int colk(input int base, input int k, input int bl);
    return (base & ~(bl - 1)) | ((base + k) & (bl - 1));
  endfunction

  function automatic logic [DW-1:0] mkword(input int salt, input int k);
    return (32'(salt) * 32'h01010101) ^ (32'(k) * 32'h00100007) ^ 32'hC3000000;
  endfunction

  // DRAM behavioural model, pins observed mid-cycle
  always @(negedge clk) begin
    logic [3:0] c;
    cyc++;
    if (sched.exists(cyc)) begin
      dq_in <= sched[cyc];
      sched.delete(cyc);
    end else begin
      dq_in <= 32'h0BAD0BAD;
    end
    c = {cs_n, ras_n, cas_n, we_n};
    if (rst) begin
      mdl_loaded = 0;
      wr_active  = 0;
      check(c == 4'b0111, "R1 reset pins NOP", c, 4'b0111);
      check(!dq_oe && !ack && !rd_valid, "R1 reset outputs low", {dq_oe, ack, rd_valid}, 0);
    end else begin
      case (c)
        4'b0000: begin
          check(a[2:0] == cur_code, "R2 mode burst code", a[2:0], cur_code);
          check(a[6:4] == 3'(cur_cl), "R2 mode CAS field", a[6:4], cur_cl);
          check(a[3] == 1'b0 && a[RW-1:7] == '0, "R2 mode other bits", a, 0);
          mdl_loaded = 1;
        end
        4'b0011: begin
          check(mdl_loaded, "R1 ACTIVE after LOAD MODE", mdl_loaded, 1);
          check(int'(ba) == exp_bank, "R3 ACTIVE bank", ba, exp_bank);
          check(int'(a) == exp_row, "R3 ACTIVE row", a, exp_row);
          act_cyc = cyc; rw_bank = int'(ba); rw_row = int'(a);
        end
        4'b0101, 4'b0100: begin
          check(cyc - act_cyc == TRCD, "R4 ACTIVE to column gap", cyc - act_cyc, TRCD);
          check(int'(ba) == rw_bank, "R4 column bank", ba, rw_bank);
          check(int'(a[CW-1:0]) == exp_col, "R4 start column", a[CW-1:0], exp_col);
          if (exp_full) check(a[10] == 1'b0, "R6 no auto precharge", a[10], 0);
          else          check(a[10] == 1'b1, "R5 auto precharge flag", a[10], 1);
          rw_cyc = cyc; rw_col = int'(a[CW-1:0]);
          if (c == 4'b0101) begin
            for (int k = 0; k < cur_bl; k++) begin
              int kk;
              kk = key(rw_bank, rw_row, colk(rw_col, k, cur_bl));
              sched[cyc + cur_cl + k] = dram_mem.exists(kk) ? dram_mem[kk] : 32'h0;
            end
          end else begin
            wr_active = 1; wr_k = 0;
          end
        end
        4'b0110: begin
          check(exp_full, "R5 no terminate on fixed burst", 1, 0);
          check(cyc - rw_cyc == PAGE, "R6 terminate position", cyc - rw_cyc, PAGE);
          wr_active = 0;
        end
        4'b0010: begin
          check(exp_full, "R5 no precharge on fixed burst", 1, 0);
          check(a[10] == 1'b0 && int'(ba) == rw_bank, "R6 single-bank precharge", {a[10], ba}, rw_bank);
        end
        default: ;
      endcase
      if (dq_oe) begin
        if (wr_active && wr_k < cur_bl) begin
          check(cyc - rw_cyc == wr_k, "R7 write beat timing", cyc - rw_cyc, wr_k);
          dram_mem[key(rw_bank, rw_row, colk(rw_col, wr_k, cur_bl))] = dq_out;
          wr_k++;
        end else begin
          check(0, "R7 bus driven outside write burst", 1, 0);
        end
      end
    end
  end

  // scoreboard monitor for read beats
  always @(negedge clk) begin
    if (!rst && rd_valid) begin
      rd_seen++;
      if (exp_q.size() == 0) begin
        check(0, "R8 unexpected read beat", rdata, 0);
      end else begin
        logic [DW-1:0] e;
        e = exp_q.pop_front();
        check(rdata == e, "R8 read beat data", rdata, e);
      end
    end
  end

  task automatic do_reset(input logic [2:0] code, input int cl);
    @(negedge clk);
    rst = 1'b1; req = 1'b0;
    cfg_burst = code; cfg_cas = 2'(cl);
    cur_code = code; cur_cl = cl;
    cur_bl = (code == 3'b111) ? PAGE : (1 << code);
    exp_full = (code == 3'b111);
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic host_write(input int b, input int r, input int c, input int salt);
    logic [DW-1:0] words[PAGE];
    int idx, n, guard;
    for (int k = 0; k < cur_bl; k++) begin
      words[k] = mkword(salt, k);
      ref_mem[key(b, r, colk(c, k, cur_bl))] = words[k];
    end
    exp_bank = b; exp_row = r; exp_col = c;
    addr = {BW'(b), RW'(r), CW'(c)};
    we = 1'b1; wdata = words[0]; req = 1'b1;
    idx = 0; n = 0; guard = 0;
    forever begin
      @(negedge clk);
      guard++;
      if (wr_next) begin
        n++; idx++;
        if (idx < cur_bl) wdata = words[idx];
      end
      if (ack || guard > 500) break;
    end
    req = 1'b0;
    check(ack, "R9 write acknowledged", ack, 1);
    check(n == cur_bl, "R7 write beat count", n, cur_bl);
    @(negedge clk);
    check(!ack, "R9 ack single cycle", ack, 0);
  endtask

  task automatic host_read(input int b, input int r, input int c);
    int guard;
    for (int k = 0; k < cur_bl; k++) begin
      int kk;
      kk = key(b, r, colk(c, k, cur_bl));
      exp_q.push_back(ref_mem.exists(kk) ? ref_mem[kk] : 32'h0);
    end
    exp_bank = b; exp_row = r; exp_col = c;
    addr = {BW'(b), RW'(r), CW'(c)};
    we = 1'b0; req = 1'b1; rd_seen = 0; guard = 0;
    forever begin
      @(negedge clk);
      guard++;
      if (ack || guard > 500) break;
    end
    req = 1'b0;
    check(ack, "R9 read acknowledged", ack, 1);
    check(rd_seen == cur_bl, "R8 beats before ack", rd_seen, cur_bl);
    check(exp_q.size() == 0, "R8 scoreboard drained", exp_q.size(), 0);
    exp_q.delete();
    @(negedge clk);
    check(!ack, "R9 ack single cycle", ack, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // burst 4, CL2; request pending straight out of reset
    do_reset(3'b010, 2);
    host_write(1, 100, 6, 1);
    host_read(1, 100, 6);
    host_write(3, 8191, 0, 2);
    host_read(3, 8191, 0);
    // burst 8, CL3, wrapping start
    do_reset(3'b011, 3);
    host_write(2, 5, 13, 3);
    host_read(2, 5, 13);
    host_read(2, 5, 8);
    // burst 1, CL1
    do_reset(3'b000, 1);
    host_write(0, 1, 3, 4);
    host_read(0, 1, 3);
    host_read(2, 5, 9);
    // full page, CL2
    do_reset(3'b111, 2);
    host_write(1, 7, 5, 5);
    host_read(1, 7, 5);
    host_read(1, 7, 0);
    // burst 2, CL3, wrap at end of pair
    do_reset(3'b001, 3);
    host_write(3, 2, 15, 6);
    host_read(3, 2, 15);
    host_read(3, 2, 14);
    repeat (5) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule